// File: doc/BRIEF.md
# Prescaled Interval Timer with Capture

This block is a 32-bit timer peripheral that sits on a plain word-wide register bus. Once enabled, a counter advances by one on every tick of a prescaler. A 3-bit select picks the tick rate from a fixed table of clock ratios. When the counter sits at the programmed threshold on a tick, it returns to zero and raises a sticky match flag. That makes the block a periodic interval source with a period of threshold+1 ticks.

A separate single-cycle capture event comes from an external conditioning block that handles synchronisation, filtering and edge choice. On that event the present counter value is frozen into a read-only capture register and a sticky capture flag is raised. The edge and filter settings are stored here and driven out to that conditioning block. Either flag may be routed to one interrupt line. Software clears a flag by writing zero to its bit.

Top module: `ptmr_top`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and the three capture configuration outputs are low.
- R2: Control bits 8:0 read back as written. Control bits 29:9 always read zero.
- R3: With enable (control bit 0) set, the counter increments once every N clock cycles. N is 2, 4, 8, 64, 128, 1024, 2048 or 4096 for prescaler select values 0 to 7, where the select is control bits 3:1. After the write that sets enable, the first increment happens exactly N cycles later.
- R4: On a tick where the counter equals the threshold, the counter becomes zero and the match flag (control bit 30) is set.
- R5: The match flag and the capture flag (control bit 30 and bit 31) stay set until a control write puts 0 in that bit. Writing 1 has no effect. A hardware set in the same cycle as a clearing write wins.
- R6: While enable is clear, the counter holds its value. The prescaler restarts from zero, so after re-enabling the first increment again takes a full N cycles.
- R7: A bus write to the counter takes effect at any time. When it coincides with a tick, the written value wins over the hardware update.
- R8: A cycle with `cap_evt_i` high copies the counter value from that cycle into the capture register and sets the capture flag. Bus writes to the capture register are ignored.
- R9: `irq_o` is high exactly when (match flag and control bit 4) or (capture flag and control bit 5).
- R10: `cap_rise_o`, `cap_fall_o` and `cap_filt_o` follow control bits 6, 7 and 8.
- R11: Registers are decoded from address bits 3:2: 0x0 control, 0x4 threshold, 0x8 counter, 0xC capture. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | 4 | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register, combinational |
| cap_evt_i | input | 1 | Conditioned capture event, one cycle per event |
| cap_rise_o | output | 1 | Rising-edge capture enable for the conditioning block |
| cap_fall_o | output | 1 | Falling-edge capture enable for the conditioning block |
| cap_filt_o | output | 1 | Filter mode for the conditioning block |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a counter write that lands exactly on a prescaler tick. The other is a flag-clearing control write that lands in the same cycle as a capture event. The bench reaches them by counting cycles from the edge that sets enable: the ticks then fall on known edges, and the counter write is placed on one of them. The capture event is driven on the same negative edge as the clearing control write, so both are sampled by the same rising edge. The longest ratio is run in full so that the end of the prescaler table is checked and not only its low entries.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned N_SEL  = 1 << SEL_W;
  localparam int unsigned PSC_W  = 12;

  localparam logic [1:0] IDX_CTRL  = 2'd0;
  localparam logic [1:0] IDX_THRES = 2'd1;
  localparam logic [1:0] IDX_CNT   = 2'd2;
  localparam logic [1:0] IDX_CAP   = 2'd3;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_IRQM  = 4;
  localparam int unsigned B_IRQC  = 5;
  localparam int unsigned B_RISE  = 6;
  localparam int unsigned B_FALL  = 7;
  localparam int unsigned B_FILT  = 8;
  localparam int unsigned B_MFLAG = 30;
  localparam int unsigned B_CFLAG = 31;

  typedef struct packed {
    logic             filt;
    logic             fall;
    logic             rise;
    logic             irqc;
    logic             irqm;
    logic [SEL_W-1:0] sel;
    logic             en;
  } ctrl_t;

  // log2 of the division ratio for each select value
  function automatic int unsigned psc_shift(logic [SEL_W-1:0] s);
    case (s)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 7;
      3'd5:    return 10;
      3'd6:    return 11;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask_tab [N_SEL];

  for (genvar g = 0; g < N_SEL; g++) begin : g_mask
    assign mask_tab[g] = PSC_W'((32'd1 << psc_shift(SEL_W'(g))) - 32'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   psc_q <= '0;
    else if (en_i) psc_q <= psc_q + 1'b1;
    else           psc_q <= '0;
  end

  assign tick_o = en_i && ((psc_q & mask_tab[sel_i]) == mask_tab[sel_i]);
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thres_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cap_evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cap_q;
  logic             hit;

  assign hit     = (cnt_q == thres_i);
  assign match_o = tick_i && hit && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (cap_evt_i) cap_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cap_i,
  input  logic              match_i,
  input  logic              cap_evt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  thres_o,
  output logic              cnt_wr_o,
  output logic              mflag_o,
  output logic              cflag_o,
  output logic              irq_o
);
  logic [1:0] idx;
  logic       addr_unused;
  logic       we_ctrl, we_thres;
  ctrl_t      ctrl_q;
  logic [CNT_W-1:0] thres_q;
  logic       mflag_q, cflag_q;
  logic       m_clr, c_clr;

  assign idx         = bus_addr_i[3:2];
  assign addr_unused = ^bus_addr_i[1:0];
  assign we_ctrl     = bus_we_i && (idx == IDX_CTRL);
  assign we_thres    = bus_we_i && (idx == IDX_THRES);
  assign cnt_wr_o    = bus_we_i && (idx == IDX_CNT);
  assign m_clr       = we_ctrl && !bus_wdata_i[B_MFLAG];
  assign c_clr       = we_ctrl && !bus_wdata_i[B_CFLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (we_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[B_FILT:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thres_q <= '0;
    else if (we_thres) thres_q <= bus_wdata_i[CNT_W-1:0];
  end

  // hardware set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mflag_q <= 1'b0;
      cflag_q <= 1'b0;
    end else begin
      mflag_q <= (mflag_q && !m_clr) || match_i;
      cflag_q <= (cflag_q && !c_clr) || cap_evt_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (idx)
      IDX_CTRL: begin
        bus_rdata_o[B_FILT:0] = ctrl_q;
        bus_rdata_o[B_MFLAG]  = mflag_q;
        bus_rdata_o[B_CFLAG]  = cflag_q;
      end
      IDX_THRES: bus_rdata_o = BUS_W'(thres_q);
      IDX_CNT:   bus_rdata_o = BUS_W'(cnt_i);
      default:   bus_rdata_o = BUS_W'(cap_i);
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign thres_o = thres_q;
  assign mflag_o = mflag_q;
  assign cflag_o = cflag_q;
  assign irq_o   = (mflag_q && ctrl_q.irqm) || (cflag_q && ctrl_q.irqc);
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              cap_evt_i,
  output logic              cap_rise_o,
  output logic              cap_fall_o,
  output logic              cap_filt_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] thres_q, cnt_q, cap_q;
  logic             cnt_wr, tick, match_evt, mflag, cflag;

  ptmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cnt_i       (cnt_q),
    .cap_i       (cap_q),
    .match_i     (match_evt),
    .cap_evt_i   (cap_evt_i),
    .ctrl_o      (ctrl),
    .thres_o     (thres_q),
    .cnt_wr_o    (cnt_wr),
    .mflag_o     (mflag),
    .cflag_o     (cflag),
    .irq_o       (irq_o)
  );

  ptmr_prescaler u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.en),
    .sel_i  (ctrl.sel),
    .tick_o (tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .thres_i   (thres_q),
    .wr_i      (cnt_wr),
    .wdata_i   (bus_wdata_i[CNT_W-1:0]),
    .cap_evt_i (cap_evt_i),
    .cnt_o     (cnt_q),
    .cap_o     (cap_q),
    .match_o   (match_evt)
  );

  assign cap_rise_o = ctrl.rise;
  assign cap_fall_o = ctrl.fall;
  assign cap_filt_o = ctrl.filt;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       idx_i,
  input logic [31:0]      wdata_i,
  input logic             en_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] thres_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cap_i,
  input logic             cap_evt_i,
  input logic             mflag_i,
  input logic             cflag_i
);
  logic cnt_wr, ctrl_wr;
  assign cnt_wr  = we_i && (idx_i == 2'd2);
  assign ctrl_wr = we_i && (idx_i == 2'd0);

  assert_tick_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && !cnt_wr) |=> $stable(cnt_i));

  assert_match_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == thres_i && !cnt_wr) |=> (cnt_i == '0) && mflag_i);

  assert_mflag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mflag_i && !(ctrl_wr && !wdata_i[30])) |=> mflag_i);

  assert_cflag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cflag_i && !(ctrl_wr && !wdata_i[31])) |=> cflag_i);

  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr) |=> $stable(cnt_i));

  assert_wr_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_i == $past(wdata_i[CNT_W-1:0]));

  assert_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (cap_i == $past(cnt_i)) && cflag_i);
endmodule

bind ptmr_top ptmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (bus_we_i),
  .idx_i     (bus_addr_i[3:2]),
  .wdata_i   (bus_wdata_i),
  .en_i      (ctrl.en),
  .tick_i    (tick),
  .thres_i   (thres_q),
  .cnt_i     (cnt_q),
  .cap_i     (cap_q),
  .cap_evt_i (cap_evt_i),
  .mflag_i   (mflag),
  .cflag_i   (cflag)
);

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT_CYC = 150000;
  localparam logic [31:0] KEEP = 32'hC000_0000;
  localparam logic [31:0] EN = 32'h1, IRQM = 32'h10, IRQC = 32'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cap_evt = 1'b0;
  logic        rise, fall, filt, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  ptmr_top dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_evt_i(cap_evt),
    .cap_rise_o(rise), .cap_fall_o(fall), .cap_filt_o(filt), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(4'(i * 4), v);
      chk("R1 reg zero", v, 32'h0);
    end
    chk("R1 irq/cfg low", {28'h0, irq, rise, fall, filt}, 32'h0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] v;
    wr(4'h0, 32'h3FFF_FFFE);
    rd(4'h0, v);
    chk("R2 ctrl readback, reserved zero", v, 32'h0000_01FE);
    chk("R10 cfg all set", {29'h0, rise, fall, filt}, 32'h7);
    wr(4'h0, 32'h0000_0040);
    rd(4'h0, v);
    chk("R2 ctrl readback rise only", v, 32'h0000_0040);
    chk("R10 cfg rise only", {29'h0, rise, fall, filt}, 32'h4);
    wr(4'h0, 32'h0000_0180);
    chk("R10 cfg fall+filt", {29'h0, rise, fall, filt}, 32'h3);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(4'h5, 32'h0000_1234);
    rd(4'h4, v);
    chk("R11 thres at 0x4 via 0x5", v, 32'h0000_1234);
    rd(4'h7, v);
    chk("R11 thres alias 0x7", v, 32'h0000_1234);
    wr(4'h8, 32'h0000_ABCD);
    rd(4'hA, v);
    chk("R11 counter at 0x8", v, 32'h0000_ABCD);
    rd(4'hC, v);
    chk("R11 capture at 0xC", v, 32'h0);
  endtask

  task automatic t_prescale(input logic [2:0] sel, input int ratio);
    logic [31:0] v;
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'h0);
    wr(4'h0, KEEP | EN | (32'(sel) << 1));
    repeat (ratio - 1) @(negedge clk);
    rd(4'h8, v);
    chk($sformatf("R3 sel%0d no early tick", sel), v, 32'd0);
    @(negedge clk);
    rd(4'h8, v);
    chk($sformatf("R3 sel%0d first tick", sel), v, 32'd1);
    repeat (ratio) @(negedge clk);
    rd(4'h8, v);
    chk($sformatf("R3 sel%0d second tick", sel), v, 32'd2);
    wr(4'h0, KEEP);
    repeat (20) @(negedge clk);
    rd(4'h8, v);
    chk($sformatf("R6 sel%0d frozen", sel), v, 32'd2);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(4'h0, KEEP | EN | (32'd1 << 1));
    repeat (2) @(negedge clk);
    wr(4'h0, KEEP);
    repeat (5) @(negedge clk);
    wr(4'h0, KEEP | EN | (32'd1 << 1));
    repeat (3) @(negedge clk);
    rd(4'h8, v);
    chk("R6 restart needs full ratio", v, 32'd2);
    @(negedge clk);
    rd(4'h8, v);
    chk("R6 restart first tick", v, 32'd3);
    wr(4'h0, KEEP);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(4'h4, 32'd3);
    wr(4'h8, 32'd0);
    wr(4'h0, KEEP | EN | IRQM);
    repeat (7) @(negedge clk);
    rd(4'h8, v);
    chk("R4 count at threshold", v, 32'd3);
    rd(4'h0, v);
    chk("R4 flag not yet", {31'h0, v[30]}, 32'd0);
    chk("R9 irq low before match", {31'h0, irq}, 32'd0);
    @(negedge clk);
    rd(4'h8, v);
    chk("R4 wrap to zero", v, 32'd0);
    rd(4'h0, v);
    chk("R4 match flag set", {31'h0, v[30]}, 32'd1);
    chk("R9 irq on match", {31'h0, irq}, 32'd1);
    wr(4'h0, KEEP | IRQM);
    rd(4'h0, v);
    chk("R5 write 1 keeps match flag", {31'h0, v[30]}, 32'd1);
    wr(4'h0, KEEP);
    rd(4'h0, v);
    chk("R9 irq masked, flag held", {30'h0, v[30], irq}, 32'b10);
    wr(4'h0, 32'h8000_0000 | IRQM);
    rd(4'h0, v);
    chk("R5 write 0 clears match flag", {31'h0, v[30]}, 32'd0);
    chk("R9 irq low after clear", {31'h0, irq}, 32'd0);
    wr(4'h0, KEEP);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    wr(4'h8, 32'h55);
    cap_evt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cap_evt = 1'b0;
    rd(4'hC, v);
    chk("R8 capture value", v, 32'h55);
    rd(4'h0, v);
    chk("R8 capture flag", {31'h0, v[31]}, 32'd1);
    chk("R9 irq off without enable", {31'h0, irq}, 32'd0);
    wr(4'h0, KEEP | IRQC);
    chk("R9 irq on capture", {31'h0, irq}, 32'd1);
    wr(4'hC, 32'hDEAD_BEEF);
    rd(4'hC, v);
    chk("R8 capture not writable", v, 32'h55);
    wr(4'h8, 32'h77);
    wr(4'h0, 32'h4000_0000 | IRQC);
    rd(4'h0, v);
    chk("R5 clear capture flag", {31'h0, v[31]}, 32'd0);
    // set and clear collide on the same edge
    addr = 4'h0; wdata = 32'h4000_0000 | IRQC; we = 1'b1; cap_evt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; cap_evt = 1'b0;
    rd(4'h0, v);
    chk("R5 set beats clear", {31'h0, v[31]}, 32'd1);
    rd(4'hC, v);
    chk("R8 capture new value", v, 32'h77);
    wr(4'h0, 32'h4000_0000);
    chk("R9 irq low", {31'h0, irq}, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'd0);
    wr(4'h0, KEEP | EN);
    @(negedge clk);
    wr(4'h8, 32'd100);
    rd(4'h8, v);
    chk("R7 write beats tick", v, 32'd100);
    @(negedge clk);
    rd(4'h8, v);
    chk("R7 no tick off-phase", v, 32'd100);
    @(negedge clk);
    rd(4'h8, v);
    chk("R7 counting resumes", v, 32'd101);
    wr(4'h0, KEEP);
  endtask

  initial begin
    repeat (TIMEOUT_CYC) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_alias();
    t_prescale(3'd0, 2);
    t_prescale(3'd2, 8);
    t_prescale(3'd3, 64);
    t_prescale(3'd5, 1024);
    t_prescale(3'd7, 4096);
    t_restart();
    t_match();
    t_capture();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule